// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits between an interrupt arbiter and a CPU core. The arbiter has already picked one pending interrupt. The block takes that interrupt only at an instruction boundary, meaning the cycle in which the core reports that the current instruction has completed. At that point it works out the processor's new interrupt priority level from the interrupt class.

After accepting, it times the interrupt sequence. The length of that sequence depends on three things: the bus width, the parity of the vector address and the stack pointer, and an extra cost for some sources. When the sequence ends, the block gives a one-cycle pulse that allows the core to fetch the first instruction of the handler. The block does not fetch vectors, write the stack or arbitrate between sources.

Top module: `irq_accept_seq`

## Requirements
- R1: While `rst_ni` is low and after it is released, `ipl_o` is 0, and `ack_o`, `busy_o` and `handler_start_o` are 0.
- R2: A request is accepted on a clock edge where `req_valid_i` and `insn_done_i` are both 1 and `busy_o` is 0. `ack_o` is 1 for exactly the one cycle that follows that edge.
- R3: For class code 0 (maskable), `ipl_o` takes the value of `req_level_i` in the same cycle as `ack_o`.
- R4: For class code 1 (watchdog) or 2 (non-maskable), `ipl_o` becomes all ones (7 for a 3-bit level) in the same cycle as `ack_o`.
- R5: For class code 3 (software), 4 (address match), 5 (debug), 6 (single step) and reserved code 7, `ipl_o` takes the value `cur_ipl_i` had at the accepting edge.
- R6: On the 16-bit bus (`bus8_i`=0), the base sequence length is 18 cycles when `vec_odd_i` and `sp_odd_i` are both 0, 20 cycles when both are 1, and 19 cycles otherwise.
- R7: On the 8-bit bus (`bus8_i`=1), the base sequence length is 20 cycles, whatever the two parity inputs are.
- R8: Some classes add cycles to the base length: class 5 adds 2, and classes 4 and 6 add 1. All other classes add nothing.
- R9: `busy_o` is 1 for exactly the sequence length L, starting in the cycle in which `ack_o` is 1. `handler_start_o` is 1 for exactly the one cycle right after `busy_o` falls.
- R10: While `busy_o` is 1, a request does not produce `ack_o` and does not change `ipl_o`.
- R11: `ipl_o` changes only in a cycle in which `ack_o` is 1.
- R12: While `insn_done_i` is 0, a valid request is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | The arbiter has a request pending |
| req_class_i | input | 3 | Interrupt class code (see R3 to R5) |
| req_level_i | input | IPL_W | Priority level of a maskable request |
| cur_ipl_i | input | IPL_W | The core's current priority level |
| insn_done_i | input | 1 | The executing instruction completes this cycle |
| bus8_i | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| vec_odd_i | input | 1 | The vector address is odd |
| sp_odd_i | input | 1 | The stack pointer is odd |
| ack_o | output | 1 | One-cycle acknowledge of the accepted request |
| ipl_o | output | IPL_W | Registered new priority level |
| busy_o | output | 1 | The interrupt sequence is in progress |
| handler_start_o | output | 1 | One-cycle pulse: the handler may be fetched |

## Verification
Both `ack_o` and the new `ipl_o` are due one register after the accepting edge. The bench therefore drives inputs on the falling edge and reads them at the next falling edge. From that cycle on, the bench counts `busy_o` once per falling edge until it drops, and compares the count with the length it computes from bus width, parity and class. `handler_start_o` is checked at the falling edge where `busy_o` is first seen low, and checked again one falling edge later to confirm it has returned to 0. During the wait for instruction completion and during the whole busy window, the request stays asserted, and every sample confirms that no acknowledge appears and the level does not move.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    CLS_MASKABLE   = 3'd0,
    CLS_WDT        = 3'd1,
    CLS_NMI        = 3'd2,
    CLS_SOFT       = 3'd3,
    CLS_ADDR_MATCH = 3'd4,
    CLS_DEBUG      = 3'd5,
    CLS_STEP       = 3'd6,
    CLS_RSVD       = 3'd7
  } irq_class_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irq_ipl_sel.sv
module irq_ipl_sel
  import irq_seq_pkg::*;
#(
  parameter int unsigned IPL_W = 3
) (
  input  irq_class_e       cls_i,
  input  logic [IPL_W-1:0] req_level_i,
  input  logic [IPL_W-1:0] cur_ipl_i,
  output logic [IPL_W-1:0] next_ipl_o
);
  always_comb begin
    unique case (cls_i)
      CLS_MASKABLE:     next_ipl_o = req_level_i;
      CLS_WDT, CLS_NMI: next_ipl_o = '1;
      default:          next_ipl_o = cur_ipl_i;
    endcase
  end
endmodule

// File: rtl/irq_seq_len.sv
module irq_seq_len
  import irq_seq_pkg::*;
#(
  parameter int unsigned LEN_W      = 5,
  parameter int unsigned BASE16     = 18,
  parameter int unsigned BASE8      = 20,
  parameter int unsigned PEN_DEBUG  = 2,
  parameter int unsigned PEN_STEP   = 1
) (
  input  irq_class_e       cls_i,
  input  logic             bus8_i,
  input  logic             vec_odd_i,
  input  logic             sp_odd_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] base_len;
  logic [LEN_W-1:0] penalty;

  // each odd address on the wide bus costs one extra access cycle
  always_comb begin
    if (bus8_i) base_len = LEN_W'(BASE8);
    else        base_len = LEN_W'(BASE16) + LEN_W'(vec_odd_i) + LEN_W'(sp_odd_i);
  end

  always_comb begin
    unique case (cls_i)
      CLS_DEBUG:                penalty = LEN_W'(PEN_DEBUG);
      CLS_ADDR_MATCH, CLS_STEP: penalty = LEN_W'(PEN_STEP);
      default:                  penalty = '0;
    endcase
  end

  assign len_o = base_len + penalty;
endmodule

// File: rtl/irq_seq_timer.sv
module irq_seq_timer #(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        busy_q <= 1'b1;
        cnt_q  <= LEN_W'(1);
        len_q  <= len_i;
      end else if (busy_q) begin
        if (cnt_q == len_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned IPL_W     = 3,
  parameter int unsigned BASE16    = 18,
  parameter int unsigned BASE8     = 20,
  parameter int unsigned PEN_DEBUG = 2,
  parameter int unsigned PEN_STEP  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_class_i,
  input  logic [IPL_W-1:0] req_level_i,
  input  logic [IPL_W-1:0] cur_ipl_i,
  input  logic             insn_done_i,
  input  logic             bus8_i,
  input  logic             vec_odd_i,
  input  logic             sp_odd_i,
  output logic             ack_o,
  output logic [IPL_W-1:0] ipl_o,
  output logic             busy_o,
  output logic             handler_start_o
);
  localparam int unsigned MAX_LEN = max_u(BASE16 + 2, BASE8) + max_u(PEN_DEBUG, PEN_STEP);
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

  irq_class_e       cls;
  logic [IPL_W-1:0] next_ipl;
  logic [LEN_W-1:0] seq_len;
  logic             accept;
  logic             busy;
  logic             ack_q;
  logic [IPL_W-1:0] ipl_q;

  assign cls    = irq_class_e'(req_class_i);
  assign accept = req_valid_i & insn_done_i & ~busy;

  irq_ipl_sel #(.IPL_W(IPL_W)) u_ipl_sel (
    .cls_i       (cls),
    .req_level_i (req_level_i),
    .cur_ipl_i   (cur_ipl_i),
    .next_ipl_o  (next_ipl)
  );

  irq_seq_len #(
    .LEN_W     (LEN_W),
    .BASE16    (BASE16),
    .BASE8     (BASE8),
    .PEN_DEBUG (PEN_DEBUG),
    .PEN_STEP  (PEN_STEP)
  ) u_seq_len (
    .cls_i     (cls),
    .bus8_i    (bus8_i),
    .vec_odd_i (vec_odd_i),
    .sp_odd_i  (sp_odd_i),
    .len_o     (seq_len)
  );

  irq_seq_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .len_i  (seq_len),
    .busy_o (busy),
    .done_o (handler_start_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      ipl_q <= '0;
    end else begin
      ack_q <= accept;
      if (accept) ipl_q <= next_ipl;
    end
  end

  assign ack_o  = ack_q;
  assign ipl_o  = ipl_q;
  assign busy_o = busy;
endmodule

// File: rtl/irq_accept_seq_chk.sv
module irq_accept_seq_chk #(
  parameter int unsigned IPL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [2:0]       req_class_i,
  input logic             insn_done_i,
  input logic             ack_o,
  input logic [IPL_W-1:0] ipl_o,
  input logic             busy_o,
  input logic             handler_start_o
);
  assert_ack_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(req_valid_i && insn_done_i));

  assert_ack_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_ipl_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ($past(req_class_i) == 3'd1 || $past(req_class_i) == 3'd2)) |-> (ipl_o == '1));

  assert_ack_opens_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> busy_o);

  assert_start_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handler_start_o |=> !handler_start_o);

  assert_start_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handler_start_o |-> ($past(busy_o) && !busy_o));

  assert_no_ack_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> !ack_o);

  assert_ipl_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> $stable(ipl_o));
endmodule

bind irq_accept_seq irq_accept_seq_chk #(.IPL_W(IPL_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_class_i     (req_class_i),
  .insn_done_i     (insn_done_i),
  .ack_o           (ack_o),
  .ipl_o           (ipl_o),
  .busy_o          (busy_o),
  .handler_start_o (handler_start_o)
);

// File: tb/irq_accept_seq_tb.sv
`timescale 1ns/1ps
module irq_accept_seq_tb;
  localparam int IPL_W = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [2:0]       req_class_i = '0;
  logic [IPL_W-1:0] req_level_i = '0;
  logic [IPL_W-1:0] cur_ipl_i = '0;
  logic             insn_done_i = 1'b0;
  logic             bus8_i = 1'b0;
  logic             vec_odd_i = 1'b0;
  logic             sp_odd_i = 1'b0;
  logic             ack_o;
  logic [IPL_W-1:0] ipl_o;
  logic             busy_o;
  logic             handler_start_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  irq_accept_seq #(.IPL_W(IPL_W)) u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_class_i, .req_level_i, .cur_ipl_i,
    .insn_done_i, .bus8_i, .vec_odd_i, .sp_odd_i,
    .ack_o, .ipl_o, .busy_o, .handler_start_o
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(int cls, int b8, int v, int s);
    int l;
    l = b8 ? 20 : 18 + v + s;
    if (cls == 5) l += 2;
    else if (cls == 4 || cls == 6) l += 1;
    return l;
  endfunction

  function automatic int exp_ipl(int cls, int lvl, int cur);
    if (cls == 0) return lvl;
    if (cls == 1 || cls == 2) return 7;
    return cur;
  endfunction

  task automatic run_seq(input int cls, input int lvl, input int cur,
                         input int b8, input int v, input int s, input int hold);
    int prev_ipl;
    int cnt;
    prev_ipl = ipl_o;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_class_i = 3'(cls);
    req_level_i = IPL_W'(lvl);
    cur_ipl_i   = IPL_W'(cur);
    bus8_i      = b8[0];
    vec_odd_i   = v[0];
    sp_odd_i    = s[0];
    insn_done_i = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_i);
      check("R12 ack while instruction runs", ack_o, 0);
      check("R11 ipl before accept", ipl_o, prev_ipl);
    end
    insn_done_i = 1'b1;
    @(negedge clk_i);
    check("R2 ack after accept", ack_o, 1);
    check("R3 R4 R5 new ipl", ipl_o, exp_ipl(cls, lvl, cur));
    prev_ipl = ipl_o;
    // competing request while busy
    req_class_i = 3'd2;
    req_level_i = IPL_W'(lvl + 3);
    cur_ipl_i   = IPL_W'(cur + 5);
    bus8_i      = ~b8[0];
    cnt = 0;
    while (busy_o && cnt < 64) begin
      cnt++;
      if (cnt > 1) check("R10 no ack while busy", ack_o, 0);
      check("R10 R11 ipl held while busy", ipl_o, prev_ipl);
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
    check("R6 R7 R8 R9 busy length", cnt, exp_len(cls, b8, v, s));
    check("R9 handler start pulse", handler_start_o, 1);
    @(negedge clk_i);
    check("R9 handler start ends", handler_start_o, 0);
    check("R2 no ack after sequence", ack_o, 0);
  endtask

  task automatic run_all();
    int idx;
    check("R1 ipl in reset", ipl_o, 0);
    check("R1 busy in reset", busy_o, 0);
    check("R1 ack in reset", ack_o, 0);
    check("R1 start in reset", handler_start_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 ipl after reset", ipl_o, 0);
    check("R1 busy after reset", busy_o, 0);
    idx = 0;
    for (int c = 0; c < 8; c++)
      for (int b = 0; b < 2; b++)
        for (int v = 0; v < 2; v++)
          for (int s = 0; s < 2; s++) begin
            run_seq(c, idx % 8, (idx * 3 + 1) % 8, b, v, s, idx % 3);
            idx++;
          end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule